// File: doc/BRIEF.md
# Serial Overhead Byte Injection Driver

This block sits beside a transmitter that takes one overhead byte through a bit-serial input port. It watches two active-high strobes from the transmitter, an enable and a frame marker, on that port's clock. When both are high on the same rising edge, a new frame's overhead is starting. The target byte is the third overhead byte, so the block first lets 16 clock periods pass. It then shifts an 8-bit value onto the serial line, most significant bit first.

Each bit is launched on a falling edge so that the transmitter can capture it on the following rising edge. The byte to send is captured from a parallel input at the moment of the trigger. An optional insert-request line is raised while the bits are on the wire. A static enable keeps that line quiet when the transmitter has already been set up to take the byte from this port.

After the eighth bit the block goes back to watching the strobes, and it repeats the sequence for every frame.

Top module: `ohb_inject`

## Requirements
- R1: While `rst_ni` is low, `ser_o` and `ins_o` are 0 and the block is idle.
- R2: A trigger is a rising edge at which `tx_en_i` and `tx_frame_i` are both 1. Either strobe high alone has no effect: the outputs stay 0.
- R3: After the trigger edge, `ser_o` and `ins_o` stay 0 on the 16 falling edges that follow rising edges 0 to 15, where rising edge 0 is the trigger edge.
- R4: Bit 7 of the byte is driven on `ser_o` at the falling edge that follows rising edge 16. Bits 6 down to 0 follow on the next seven falling edges, one bit per edge, so that each bit is stable at the rising edge after it is launched.
- R5: The byte sent is the value of `byte_i` at the trigger edge. Later changes to `byte_i` do not alter the bits on the wire.
- R6: `ins_o` is 1 on exactly the eight falling-edge bit slots of R4 when `ins_use_i` is 1. When `ins_use_i` is 0, `ins_o` is always 0.
- R7: On the falling edge after rising edge 24, `ser_o` returns to 0. A trigger at rising edge 25 starts a new sequence, so frames can run back to back.
- R8: Strobes seen during the wait or the shift do not restart or extend the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Overhead port clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Enable strobe from the transmitter |
| tx_frame_i | input | 1 | Frame strobe from the transmitter |
| byte_i | input | 8 | Byte to inject, captured at the trigger |
| ins_use_i | input | 1 | Allows the insert-request line to be driven |
| ser_o | output | 1 | Serial data, launched on falling edges |
| ins_o | output | 1 | Insert request while the byte is on the wire |

## Verification
A wrong wait count or a wrong bit index shows at once as a shifted or misordered bit pattern on `ser_o`. It is visible within the 25 falling edges of one frame. A state machine that fails to return to idle, or that restarts on a stray strobe, shows up as a missing or duplicated byte in the next back-to-back frame. Corruption of the captured byte shows up during that same shift. The bench compares every falling-edge sample against a queue of expected bits, so each of these faults appears as a mismatch within one frame.

// File: rtl/ohb_inject_pkg.sv
package ohb_inject_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } inj_state_e;
endpackage

// File: rtl/ohb_seq.sv
module ohb_seq
  import ohb_inject_pkg::*;
#(
  parameter int WAIT_CYCLES = 16,
  parameter int BYTE_W      = 8,
  localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1,
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              tx_frame_i,
  input  logic [BYTE_W-1:0] byte_i,
  output inj_state_e        state_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BYTE_W-1:0] byte_q_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(BYTE_W - 1);

  inj_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] byte_q;
  logic              trig;

  assign trig = tx_en_i & tx_frame_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      byte_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (trig) begin
          state_q <= ST_WAIT;
          cnt_q   <= '0;
          byte_q  <= byte_i;
        end
        ST_WAIT: if (cnt_q == CNT_LAST) begin
          state_q <= ST_SHIFT;
          idx_q   <= IDX_TOP;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ST_SHIFT: if (idx_q == '0) state_q <= ST_IDLE;
                  else idx_q <= idx_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign idx_o    = idx_q;
  assign byte_q_o = byte_q;

  // R2
  no_false_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !trig) |=> state_q == ST_IDLE);
  // R3
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && cnt_q != CNT_LAST) |=> (state_q == ST_WAIT && cnt_q == $past(cnt_q) + 1'b1));
  // R4
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && idx_q != '0) |=> (state_q == ST_SHIFT && idx_q == $past(idx_q) - 1'b1));
  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |=> state_q != ST_IDLE);
  // R5
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(byte_q) || $past(state_q) == ST_IDLE);
endmodule

// File: rtl/ohb_launch.sv
module ohb_launch
  import ohb_inject_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  inj_state_e        state_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_q_i,
  input  logic              ins_use_i,
  output logic              ser_o,
  output logic              ins_o
);
  logic in_shift;
  assign in_shift = (state_i == ST_SHIFT);

  // falling-edge launch so the transmitter captures on the next rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_o <= 1'b0;
      ins_o <= 1'b0;
    end else begin
      ser_o <= in_shift & byte_q_i[idx_i];
      ins_o <= in_shift & ins_use_i;
    end
  end

  // R3
  quiet_ser_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_o |-> in_shift);
  // R6
  quiet_ins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |-> in_shift);
  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!ser_o && !ins_o));
endmodule

// File: rtl/ohb_inject.sv
module ohb_inject
  import ohb_inject_pkg::*;
#(
  parameter int WAIT_CYCLES = 16,
  parameter int BYTE_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              tx_frame_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ins_use_i,
  output logic              ser_o,
  output logic              ins_o
);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  inj_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] byte_q;

  ohb_seq #(.WAIT_CYCLES(WAIT_CYCLES), .BYTE_W(BYTE_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .tx_frame_i (tx_frame_i),
    .byte_i     (byte_i),
    .state_o    (state),
    .idx_o      (idx),
    .byte_q_o   (byte_q)
  );

  ohb_launch #(.BYTE_W(BYTE_W)) u_launch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .idx_i     (idx),
    .byte_q_i  (byte_q),
    .ins_use_i (ins_use_i),
    .ser_o     (ser_o),
    .ins_o     (ins_o)
  );
endmodule

// File: tb/ohb_inject_tb.sv
module ohb_inject_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  ser;
    logic  ins;
    string tag;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en_i = 1'b0;
  logic       tx_frame_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       ins_use_i = 1'b0;
  logic       ser_o, ins_o;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_on = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ohb_inject dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .tx_frame_i(tx_frame_i),
    .byte_i(byte_i), .ins_use_i(ins_use_i), .ser_o(ser_o), .ins_o(ins_o)
  );

  task automatic check(input string tag, input logic act_s, input logic exp_s,
                       input logic act_i, input logic exp_i);
    n_chk++;
    if (act_s !== exp_s || act_i !== exp_i) begin
      n_fail++;
      $display("FAIL %s: ser/ins actual %b/%b expected %b/%b at %0t",
               tag, act_s, act_i, exp_s, exp_i, $time);
    end
  endtask

  // monitor: one sample per falling edge, a quarter period after it
  initial begin
    forever begin
      @(negedge clk_i);
      #(CLK_PERIOD/4);
      if (mon_on) begin
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.tag, ser_o, e.ser, ins_o, e.ins);
        end else begin
          check("R2/R7 idle", ser_o, 1'b0, ins_o, 1'b0);
        end
      end
    end
  end

  // driver: caller is at a falling edge; trigger is sampled on the next rising edge
  task automatic send(input logic [7:0] b, input logic use_ins,
                      input bit glitch, input bit change);
    tx_en_i    = 1'b1;
    tx_frame_i = 1'b1;
    byte_i     = b;
    ins_use_i  = use_ins;
    for (int i = 1; i <= 25; i++) begin
      @(negedge clk_i);
      if (i == 1) begin
        for (int j = 0; j < 16; j++) exp_q.push_back('{1'b0, 1'b0, "R3 wait"});
        for (int j = 7; j >= 0; j--)
          exp_q.push_back('{b[j], use_ins, (glitch || change) ? "R5/R8 bit" : "R4/R6 bit"});
        exp_q.push_back('{1'b0, 1'b0, "R7 end"});
      end
      if (glitch && (i == 5 || i == 20)) begin
        tx_en_i = 1'b1; tx_frame_i = 1'b1;
      end else begin
        tx_en_i = 1'b0; tx_frame_i = 1'b0;
      end
      if (change && i == 18) byte_i = ~b;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #(CLK_PERIOD/4);
    check("R1 reset", ser_o, 1'b0, ins_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    repeat (3) @(negedge clk_i);
    // R2: single strobes must not trigger
    tx_en_i = 1'b1;
    @(negedge clk_i);
    tx_en_i = 1'b0; tx_frame_i = 1'b1;
    @(negedge clk_i);
    tx_frame_i = 1'b0;
    repeat (30) @(negedge clk_i);
    send(8'hA5, 1'b1, 1'b0, 1'b0);
    send(8'h3C, 1'b0, 1'b0, 1'b0);  // R7 back to back, R6 insert disabled
    send(8'h81, 1'b1, 1'b1, 1'b1);  // R8 stray strobes, R5 byte change mid-frame
    send(8'hFF, 1'b1, 1'b0, 1'b0);
    repeat (4) @(negedge clk_i);
    send(8'h00, 1'b1, 1'b0, 1'b0);
    repeat (6) @(negedge clk_i);
    #(CLK_PERIOD/2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule